// File: doc/BRIEF.md
# UART FIFO Service Threshold Resolver

This block turns the per-direction trigger fields of a UART with 64-entry FIFOs into two 6-bit thresholds. It compares each threshold with the live FIFO occupancy figure and raises a level-type service request that an interrupt controller or a DMA engine can consume. The transmit side compares against the number of free slots. The receive side compares against the number of stored characters.

Each direction has three encodings, and two fields select among them. With the unit-step bit clear and a zero fine code, a 2-bit code indexes a fixed table, and the transmit and receive tables differ. With the unit-step bit clear and a non-zero fine code, the threshold is four times the fine code. With the unit-step bit set, the fine code and the 2-bit code are joined into a 6-bit value. An all-zero joined value has no legal meaning. The block substitutes a threshold of one for it and records the event in a sticky error flag.

The thresholds are purely combinational from the fields. The request and error outputs are registered, so they reflect the inputs present at the previous rising clock edge.

Top module: `fifo_thresh_gen`

## Requirements
- R1: With `tx_unit_step`=0 and `tx_fine_code`=0, `tx_threshold` is 8, 16, 32 or 56 for `tx_legacy_code` 0, 1, 2 or 3.
- R2: With `rx_unit_step`=0 and `rx_fine_code`=0, `rx_threshold` is 8, 16, 56 or 60 for `rx_legacy_code` 0, 1, 2 or 3.
- R3: With the unit-step bit 0 and a non-zero fine code F, the threshold of that direction is 4×F.
- R4: With the unit-step bit 1, the threshold is the fine code in bits [5:2] joined with the 2-bit code in bits [1:0], provided that value is non-zero.
- R5: With the unit-step bit 1 and both fields zero, the threshold of that direction is 1.
- R6: `config_error` is 0 after reset. It is 1 from the cycle after any clock edge at which either direction has the all-zero unit-step setting, and it stays 1 until reset.
- R7: After each rising edge, `tx_req` equals (`tx_free_cnt` ≥ `tx_threshold`) as sampled at that edge.
- R8: After each rising edge, `rx_req` equals (`rx_fill_cnt` ≥ `rx_threshold`) as sampled at that edge.
- R9: While `rst_n` is low, `tx_req`, `rx_req` and `config_error` are 0.
- R10: The fields of one direction have no effect on the threshold of the other direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_legacy_code | input | 2 | Transmit table index / low bits in unit-step mode |
| tx_fine_code | input | 4 | Transmit fine code |
| tx_unit_step | input | 1 | Transmit single-step encoding select |
| rx_legacy_code | input | 2 | Receive table index / low bits in unit-step mode |
| rx_fine_code | input | 4 | Receive fine code |
| rx_unit_step | input | 1 | Receive single-step encoding select |
| tx_free_cnt | input | 7 | Free slots in the transmit FIFO (0..64) |
| rx_fill_cnt | input | 7 | Characters held in the receive FIFO (0..64) |
| tx_threshold | output | 6 | Resolved transmit threshold |
| rx_threshold | output | 6 | Resolved receive threshold |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| config_error | output | 1 | Sticky illegal-setting flag |

## Verification
The bench sweeps every field combination of both directions. It places each count one below, at and one above the resolved threshold, so a comparison written as strict greater-than would drop the request exactly at the threshold. A design that swapped the transmit and receive tables would give 32 instead of 56 on code 2, and one that let a zero fine code fall into the coarse path would give a threshold of 0. The all-zero unit-step setting is driven and then cleared. A design that passed 0 through would keep the request asserted at an empty count, and one with a non-sticky error flag would drop `config_error` once legal fields return. A reset in the middle of the run confirms that the flag and both requests clear.

// File: rtl/fifo_thresh_pkg.sv
package fifo_thresh_pkg;

    typedef struct packed {
        logic tx_req;
        logic rx_req;
        logic cfg_err;
    } req_state_t;

endpackage

// File: rtl/thresh_resolve.sv
module thresh_resolve #(
    parameter int THR_W  = 6,
    parameter int LEG_W  = 2,
    parameter int FINE_W = 4,
    parameter bit IS_RX  = 1'b0
) (
    input  logic [LEG_W-1:0]  legacy_code,
    input  logic [FINE_W-1:0] fine_code,
    input  logic              unit_step,
    output logic [THR_W-1:0]  threshold,
    output logic              zero_cfg
);
    localparam int COARSE_SH = THR_W - FINE_W;
    localparam int TAB_N     = 1 << LEG_W;

    logic [THR_W-1:0] legacy_val_d;
    logic [THR_W-1:0] coarse_val_d;
    logic [THR_W-1:0] joined_val_d;

    generate
        if (IS_RX) begin : g_rx_tab
            localparam logic [THR_W-1:0] RX_TAB [TAB_N] = '{
                THR_W'(8), THR_W'(16), THR_W'(56), THR_W'(60)};
            assign legacy_val_d = RX_TAB[legacy_code];
        end else begin : g_tx_tab
            localparam logic [THR_W-1:0] TX_TAB [TAB_N] = '{
                THR_W'(8), THR_W'(16), THR_W'(32), THR_W'(56)};
            assign legacy_val_d = TX_TAB[legacy_code];
        end
    endgenerate

    always_comb begin
        coarse_val_d = {fine_code, {COARSE_SH{1'b0}}};
        joined_val_d = {fine_code, legacy_code};
        zero_cfg     = unit_step && (joined_val_d == '0);
        if (unit_step) begin
            threshold = zero_cfg ? THR_W'(1) : joined_val_d;
        end else if (fine_code != '0) begin
            threshold = coarse_val_d;
        end else begin
            threshold = legacy_val_d;
        end
    end

    always_comb begin
        if (!$isunknown({legacy_code, fine_code, unit_step})) begin
            assert_thr_nonzero_R5: assert (threshold != '0)
                else $error("threshold resolved to zero");
            if (!unit_step && fine_code != '0) begin
                assert_coarse_step_R3: assert (threshold[1:0] == 2'b00)
                    else $error("coarse threshold not a multiple of four");
            end
        end
    end

endmodule

// File: rtl/req_regs.sv
module req_regs
    import fifo_thresh_pkg::*;
#(
    parameter int THR_W = 6,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic             tx_zero,
    input  logic             rx_zero,
    output logic             tx_req,
    output logic             rx_req,
    output logic             cfg_err
);
    req_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.tx_req  = tx_cnt >= CNT_W'(tx_thr);
        st_d.rx_req  = rx_cnt >= CNT_W'(rx_thr);
        st_d.cfg_err = st_q.cfg_err | tx_zero | rx_zero;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_req  = st_q.tx_req;
    assign rx_req  = st_q.rx_req;
    assign cfg_err = st_q.cfg_err;

    assert_tx_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt >= CNT_W'(tx_thr)) |=> tx_req)
        else $error("tx_req missing");
    assert_tx_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt < CNT_W'(tx_thr)) |=> !tx_req)
        else $error("tx_req spurious");
    assert_rx_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt >= CNT_W'(rx_thr)) |=> rx_req)
        else $error("rx_req missing");
    assert_rx_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt < CNT_W'(rx_thr)) |=> !rx_req)
        else $error("rx_req spurious");
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err)
        else $error("config error cleared");
    assert_err_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_zero || rx_zero) |=> cfg_err)
        else $error("config error not raised");

endmodule

// File: rtl/fifo_thresh_gen.sv
module fifo_thresh_gen #(
    parameter int DEPTH  = 64,
    parameter int LEG_W  = 2,
    parameter int FINE_W = 4,
    localparam int THR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEG_W-1:0]  tx_legacy_code,
    input  logic [FINE_W-1:0] tx_fine_code,
    input  logic              tx_unit_step,
    input  logic [LEG_W-1:0]  rx_legacy_code,
    input  logic [FINE_W-1:0] rx_fine_code,
    input  logic              rx_unit_step,
    input  logic [CNT_W-1:0]  tx_free_cnt,
    input  logic [CNT_W-1:0]  rx_fill_cnt,
    output logic [THR_W-1:0]  tx_threshold,
    output logic [THR_W-1:0]  rx_threshold,
    output logic              tx_req,
    output logic              rx_req,
    output logic              config_error
);
    logic tx_zero, rx_zero;

    thresh_resolve #(.THR_W(THR_W), .LEG_W(LEG_W), .FINE_W(FINE_W), .IS_RX(1'b0)) u_tx_res (
        .legacy_code (tx_legacy_code),
        .fine_code   (tx_fine_code),
        .unit_step   (tx_unit_step),
        .threshold   (tx_threshold),
        .zero_cfg    (tx_zero)
    );

    thresh_resolve #(.THR_W(THR_W), .LEG_W(LEG_W), .FINE_W(FINE_W), .IS_RX(1'b1)) u_rx_res (
        .legacy_code (rx_legacy_code),
        .fine_code   (rx_fine_code),
        .unit_step   (rx_unit_step),
        .threshold   (rx_threshold),
        .zero_cfg    (rx_zero)
    );

    req_regs #(.THR_W(THR_W), .CNT_W(CNT_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_thr  (tx_threshold),
        .rx_thr  (rx_threshold),
        .tx_cnt  (tx_free_cnt),
        .rx_cnt  (rx_fill_cnt),
        .tx_zero (tx_zero),
        .rx_zero (rx_zero),
        .tx_req  (tx_req),
        .rx_req  (rx_req),
        .cfg_err (config_error)
    );

endmodule

// File: tb/sim_fifo_thresh_gen.sv
`timescale 1ns/1ps
module sim_fifo_thresh_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tx_leg = '0, rx_leg = '0;
    logic [3:0] tx_fine = '0, rx_fine = '0;
    logic       tx_unit = 1'b0, rx_unit = 1'b0;
    logic [6:0] tx_cnt = '0, rx_cnt = '0;
    logic [5:0] tx_thr, rx_thr;
    logic       tx_req, rx_req, cfg_err;

    int checks = 0;
    int errors = 0;
    bit exp_tx = 0, exp_rx = 0, exp_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fifo_thresh_gen u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_legacy_code(tx_leg), .tx_fine_code(tx_fine), .tx_unit_step(tx_unit),
        .rx_legacy_code(rx_leg), .rx_fine_code(rx_fine), .rx_unit_step(rx_unit),
        .tx_free_cnt(tx_cnt), .rx_fill_cnt(rx_cnt),
        .tx_threshold(tx_thr), .rx_threshold(rx_thr),
        .tx_req(tx_req), .rx_req(rx_req), .config_error(cfg_err)
    );

    function automatic int ref_thr(bit is_rx, int leg, int fine, bit unit);
        int v;
        if (unit) begin
            v = fine * 4 + leg;
            return (v == 0) ? 1 : v;
        end
        if (fine != 0) return fine * 4;
        if (is_rx) begin
            case (leg) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
        end
        case (leg) 0: return 8; 1: return 16; 2: return 32; default: return 56; endcase
    endfunction

    function automatic string mode_tag(bit is_rx, int leg, int fine, bit unit);
        if (unit) return (fine == 0 && leg == 0) ? "R5" : "R4";
        if (fine != 0) return "R3";
        return is_rx ? "R2" : "R1";
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model of the registered outputs
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_tx <= 0; exp_rx <= 0; exp_err <= 0;
        end else begin
            exp_tx  <= int'(tx_cnt) >= ref_thr(0, tx_leg, tx_fine, tx_unit);
            exp_rx  <= int'(rx_cnt) >= ref_thr(1, rx_leg, rx_fine, rx_unit);
            exp_err <= exp_err | (tx_unit && tx_fine == 0 && tx_leg == 0)
                               | (rx_unit && rx_fine == 0 && rx_leg == 0);
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tx_req == exp_tx, "R7", tx_req, exp_tx);
            chk(rx_req == exp_rx, "R8", rx_req, exp_rx);
            chk(cfg_err == exp_err, "R6", cfg_err, exp_err);
        end
    end

    task automatic drive(int tl, int tf, bit tu, int rl, int rf, bit ru, int tc, int rc);
        int et, er;
        @(negedge clk);
        #1;
        tx_leg = 2'(tl); tx_fine = 4'(tf); tx_unit = tu;
        rx_leg = 2'(rl); rx_fine = 4'(rf); rx_unit = ru;
        tx_cnt = 7'(tc); rx_cnt = 7'(rc);
        #1;
        et = ref_thr(0, tl, tf, tu);
        er = ref_thr(1, rl, rf, ru);
        chk(int'(tx_thr) == et, mode_tag(0, tl, tf, tu), tx_thr, et);
        chk(int'(rx_thr) == er, mode_tag(1, rl, rf, ru), rx_thr, er);
    endtask

    function automatic int clampc(int v);
        return (v < 0) ? 0 : (v > 64) ? 64 : v;
    endfunction

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tx_cnt = 7'd64; rx_cnt = 7'd64;
        repeat (3) @(negedge clk);
        // R9: reset holds outputs low even with full counts
        chk(tx_req == 0 && rx_req == 0 && cfg_err == 0, "R9", {tx_req, rx_req, cfg_err}, 0);
        @(negedge clk); rst_n = 1'b1;

        // exhaustive sweep of legal settings, counts around each threshold
        for (int i = 0; i < 128; i++) begin
            int tl = i % 4, tf = (i / 4) % 16, rl, rf, tt, rt;
            bit tu = i[6], ru;
            int j = (i * 37 + 5) % 128;
            rl = j % 4; rf = (j / 4) % 16; ru = j[6];
            if (tu && tf == 0 && tl == 0) tu = 0;
            if (ru && rf == 0 && rl == 0) ru = 0;
            tt = ref_thr(0, tl, tf, tu);
            rt = ref_thr(1, rl, rf, ru);
            for (int d = -1; d <= 1; d++)
                drive(tl, tf, tu, rl, rf, ru, clampc(tt + d), clampc(rt - d));
        end

        // R10: sweeping transmit fields leaves the receive threshold alone
        for (int k = 0; k < 16; k++) begin
            drive(k % 4, k, k[0], 2, 0, 0, 10, 20);
            chk(rx_thr == 6'd56, "R10", rx_thr, 56);
        end
        for (int k = 0; k < 16; k++) begin
            drive(3, 0, 0, k % 4, k, k[1], 10, 20);
            chk(tx_thr == 6'd56, "R10", tx_thr, 56);
        end

        // random traffic on legal settings
        for (int k = 0; k < 200; k++) begin
            int tl = $urandom_range(3), tf = $urandom_range(15);
            int rl = $urandom_range(3), rf = $urandom_range(15);
            bit tu = 1'($urandom_range(1)), ru = 1'($urandom_range(1));
            if (tu && tf == 0 && tl == 0) tl = 1;
            if (ru && rf == 0 && rl == 0) rl = 2;
            drive(tl, tf, tu, rl, rf, ru, $urandom_range(64), $urandom_range(64));
        end
        @(negedge clk);
        chk(cfg_err == 0, "R6", cfg_err, 0);

        // R5: all-zero unit-step on transmit, zero and one free slots
        drive(0, 0, 1, 0, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 0, 1, 8);
        @(negedge clk);
        chk(cfg_err == 1, "R6", cfg_err, 1);
        chk(tx_req == 1, "R5", tx_req, 1);
        // back to legal settings: flag must stay
        for (int k = 0; k < 5; k++) drive(2, 0, 0, 1, 0, 0, 40, 15);
        chk(cfg_err == 1, "R6", cfg_err, 1);

        // reset mid-run clears the flag
        @(negedge clk); rst_n = 1'b0;
        #2;
        chk(cfg_err == 0 && tx_req == 0 && rx_req == 0, "R9", {tx_req, rx_req, cfg_err}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R5 on receive: one stored character is enough
        drive(0, 0, 0, 0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 0, 1);
        @(negedge clk);
        chk(rx_req == 1, "R5", rx_req, 1);
        chk(cfg_err == 1, "R6", cfg_err, 1);
        repeat (2) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule